// File: doc/BRIEF.md
# Counter-Based Edge-Gap Phase Detector

This block measures how far apart a reference clock edge and a divided feedback clock edge lie. Both slow clocks are sampled in a fast counting-clock domain. The first rising edge seen on either input opens a measurement window. The counter then advances once per fast cycle until the other input rises, which closes the window. The block then reports the number of fast cycles between the two edges and which input rose first. A frequency-acquisition controller uses the magnitude to size its next tuning step and uses the lead/lag bit to choose the direction of that step.

The result is held in output registers and announced by a single-cycle strobe. It stays unchanged until the next result replaces it. If the gap is longer than the counter can hold, the count stops at full scale and a separate overflow bit is set.

Top module: `edge_gap_tdc`

## Requirements
- R1: While rst_ni is low, count_o, ref_lead_o, overflow_o and valid_o are all 0.
- R2: If one input rises and the other input rises d fast-clock cycles later (0 < d <= 511), the reported count_o equals d.
- R3: ref_lead_o is 1 when the reference input rose first and 0 when the feedback input rose first.
- R4: If both inputs rise in the same fast-clock cycle, the result is count_o = 0 with ref_lead_o = 1.
- R5: The counter saturates at 511 and does not wrap. For d > 511, count_o = 511 and overflow_o = 1. For d <= 511, overflow_o = 0.
- R6: valid_o is high for exactly one fast-clock cycle per result. It rises on the third rising edge of clk_i after the later input goes high, which is two synchronizer flops plus one result register.
- R7: count_o, ref_lead_o and overflow_o change only in the cycle in which valid_o is high, and hold their values between pulses.
- R8: While a window is open, further rising edges of the leading input are ignored, so the count runs from the first leading edge. A leading-input edge that arrives in the same cycle as the closing edge does not open a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk_i |
| fb_clk_i | input | 1 | Divided feedback clock, asynchronous to clk_i |
| count_o | output | 9 | Fast-cycle gap between the two edges, saturating |
| ref_lead_o | output | 1 | 1 when the reference edge came first or both came together |
| overflow_o | output | 1 | Gap exceeded the counter range |
| valid_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest cases to reach from the ports are the saturation boundary and the tie. The saturation boundary needs the window held open for exactly 511 and then 512 fast cycles. The tie needs both synchronized edges to land in the same sampling cycle. The stimulus drives both inputs on the same falling edge of clk_i to force a tie. It also spaces the second edge by an exact number of falling edges, so that gaps of 511, 512 and 600 cycles fall on both sides of full scale. To reach R8, a separate run toggles the leading input several times inside an open window. Another run raises the leading input in the same cycle as the closing edge.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic {
    WIN_IDLE  = 1'b0,
    WIN_ARMED = 1'b1
  } win_state_e;

  localparam int unsigned SRC_REF = 0;
  localparam int unsigned SRC_FB  = 1;
  localparam int unsigned N_SRC   = 2;
endpackage

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
  parameter int unsigned N_SIG  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SIG-1:0] sig_i,
  output logic [N_SIG-1:0] rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < N_SIG; g++) begin : g_sig
    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[DEPTH-2:0], sig_i[g]};
    end

    // last sync flop high, history flop low
    assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/tdc_window_ctrl.sv
module tdc_window_ctrl
  import tdc_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  output logic             close_o,
  output logic [CNT_W-1:0] close_cnt_o,
  output logic             close_ref_lead_o,
  output logic             close_ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  win_state_e       state_q, state_d;
  logic             lead_ref_q, lead_ref_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sat_q, sat_d;
  logic             trail_rise;

  assign trail_rise = lead_ref_q ? fb_rise_i : ref_rise_i;

  always_comb begin
    state_d          = state_q;
    lead_ref_d       = lead_ref_q;
    cnt_d            = cnt_q;
    sat_d            = sat_q;
    close_o          = 1'b0;
    close_cnt_o      = '0;
    close_ref_lead_o = 1'b1;
    close_ovf_o      = 1'b0;
    unique case (state_q)
      WIN_IDLE: begin
        if (ref_rise_i && fb_rise_i) begin
          close_o = 1'b1;
        end else if (ref_rise_i || fb_rise_i) begin
          state_d    = WIN_ARMED;
          lead_ref_d = ref_rise_i;
          cnt_d      = CNT_ONE;
          sat_d      = 1'b0;
        end
      end
      WIN_ARMED: begin
        if (trail_rise) begin
          close_o          = 1'b1;
          close_cnt_o      = cnt_q;
          close_ref_lead_o = lead_ref_q;
          close_ovf_o      = sat_q;
          state_d          = WIN_IDLE;
        end else if (cnt_q == CNT_MAX) begin
          sat_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= WIN_IDLE;
      lead_ref_q <= 1'b1;
      cnt_q      <= '0;
      sat_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      lead_ref_q <= lead_ref_d;
      cnt_q      <= cnt_d;
      sat_q      <= sat_d;
    end
  end
endmodule

// File: rtl/tdc_result_reg.sv
module tdc_result_reg #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ref_lead_i,
  input  logic             ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_lead_o,
  output logic             ovf_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o      <= '0;
      ref_lead_o <= 1'b0;
      ovf_o      <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        cnt_o      <= cnt_i;
        ref_lead_o <= ref_lead_i;
        ovf_o      <= ovf_i;
      end
    end
  end
endmodule

// File: rtl/edge_gap_tdc.sv
module edge_gap_tdc
  import tdc_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ref_lead_o,
  output logic             overflow_o,
  output logic             valid_o
);
  logic [N_SRC-1:0] src_raw;
  logic [N_SRC-1:0] src_rise;
  logic             close;
  logic [CNT_W-1:0] close_cnt;
  logic             close_ref_lead;
  logic             close_ovf;

  assign src_raw[SRC_REF] = ref_clk_i;
  assign src_raw[SRC_FB]  = fb_clk_i;

  tdc_edge_sync #(
    .N_SIG (N_SRC),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (src_raw),
    .rise_o(src_rise)
  );

  tdc_window_ctrl #(
    .CNT_W(CNT_W)
  ) u_win (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ref_rise_i      (src_rise[SRC_REF]),
    .fb_rise_i       (src_rise[SRC_FB]),
    .close_o         (close),
    .close_cnt_o     (close_cnt),
    .close_ref_lead_o(close_ref_lead),
    .close_ovf_o     (close_ovf)
  );

  tdc_result_reg #(
    .CNT_W(CNT_W)
  ) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (close),
    .cnt_i     (close_cnt),
    .ref_lead_i(close_ref_lead),
    .ovf_i     (close_ovf),
    .cnt_o     (count_o),
    .ref_lead_o(ref_lead_o),
    .ovf_o     (overflow_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/edge_gap_tdc_chk.sv
module edge_gap_tdc_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic             ref_lead_o,
  input logic             overflow_o,
  input logic             valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r7_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(count_o) && $stable(ref_lead_o) && $stable(overflow_o)));

  a_r5_ovf_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (count_o == CNT_MAX));

  a_r4_tie_ref_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && count_o == '0) |-> ref_lead_o);
endmodule

bind edge_gap_tdc edge_gap_tdc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_o   (count_o),
  .ref_lead_o(ref_lead_o),
  .overflow_o(overflow_o),
  .valid_o   (valid_o)
);

// File: tb/edge_gap_tdc_tb.sv
module edge_gap_tdc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_clk = 1'b0;
  logic       fb_clk = 1'b0;
  logic [8:0] count;
  logic       ref_lead, overflow, valid;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_gap_tdc u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_clk_i (ref_clk),
    .fb_clk_i  (fb_clk),
    .count_o   (count),
    .ref_lead_o(ref_lead),
    .overflow_o(overflow),
    .valid_o   (valid)
  );

  // behavioural reference model
  bit [2:0] pr, pf;
  int  m_arm, m_j;
  bit  m_lead;
  bit  m_valid, m_ld, m_ovf;
  int  m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr = '0; pf = '0; m_arm = 0; m_j = 0; m_lead = 1;
      m_valid = 0; m_ld = 0; m_ovf = 0; m_cnt = 0;
    end else begin
      bit rr, rf, other;
      rr = pr[1] & ~pr[2];
      rf = pf[1] & ~pf[2];
      m_valid = 0;
      if (m_arm == 0) begin
        if (rr && rf) begin
          m_valid = 1; m_cnt = 0; m_ld = 1; m_ovf = 0;
        end else if (rr || rf) begin
          m_arm = 1; m_lead = rr; m_j = 1;
        end
      end else begin
        other = m_lead ? rf : rr;
        if (other) begin
          m_valid = 1; m_ld = m_lead;
          m_cnt = (m_j > 511) ? 511 : m_j;
          m_ovf = (m_j > 511);
          m_arm = 0;
        end else m_j++;
      end
      pr = {pr[1:0], ref_clk};
      pf = {pf[1:0], fb_clk};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      chk(count == 0 && !ref_lead && !overflow && !valid, "R1",
          {count, ref_lead, overflow, valid}, 0);
    end else if (!done) begin
      chk(valid == m_valid, "R6", valid, m_valid);
      chk(count == 9'(m_cnt), "R2", count, m_cnt);
      chk(ref_lead == m_ld, "R3", ref_lead, m_ld);
      chk(overflow == m_ovf, "R5", overflow, m_ovf);
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // first: 0 ref leads, 1 fb leads; d = gap in cycles
  task automatic measure(input bit fb_first, input int d, input int exp_cnt,
                         input bit exp_ld, input bit exp_ovf, input string req);
    @(negedge clk);
    if (d == 0) begin
      ref_clk = 1; fb_clk = 1;
    end else begin
      if (fb_first) fb_clk = 1; else ref_clk = 1;
      idle(d);
      if (fb_first) ref_clk = 1; else fb_clk = 1;
    end
    idle(3);
    chk(valid == 1'b1, {req, "/R6 strobe"}, valid, 1);
    chk(count == 9'(exp_cnt), {req, " count"}, count, exp_cnt);
    chk(ref_lead == exp_ld, {req, " lead"}, ref_lead, exp_ld);
    chk(overflow == exp_ovf, {req, " ovf"}, overflow, exp_ovf);
    idle(1);
    chk(valid == 1'b0, "R6 one cycle", valid, 0);
    ref_clk = 0; fb_clk = 0;
    idle(4);
  endtask

  initial begin
    logic [8:0] held;
    idle(3);
    rst_n = 1;
    idle(4);
    measure(0, 5, 5, 1, 0, "R2 ref-first");
    measure(1, 9, 9, 0, 0, "R3 fb-first");
    measure(0, 1, 1, 1, 0, "R2 gap one");
    measure(0, 0, 0, 1, 0, "R4 tie");
    measure(1, 37, 37, 0, 0, "R3 fb-first long");
    measure(0, 511, 511, 1, 0, "R5 at full scale");
    measure(1, 512, 511, 0, 1, "R5 just over");
    measure(0, 600, 511, 1, 1, "R5 far over");
    measure(0, 2, 2, 1, 0, "R5 ovf clears");

    // R7: result held while idle
    held = count;
    idle(20);
    chk(count == held && !valid, "R7 hold", count, held);

    // R8: leader re-toggles inside window
    @(negedge clk); ref_clk = 1;
    idle(3); ref_clk = 0; idle(2); ref_clk = 1; idle(3); ref_clk = 0; idle(2);
    fb_clk = 1;
    idle(3);
    chk(valid && count == 10 && ref_lead, "R8 retoggle", count, 10);
    ref_clk = 0; fb_clk = 0; idle(4);

    // R8: leader rises again in the closing cycle, no new window
    @(negedge clk); fb_clk = 1;
    idle(4); fb_clk = 0; idle(2);
    ref_clk = 1; fb_clk = 1;
    idle(3);
    chk(valid && count == 6 && !ref_lead, "R8 close", count, 6);
    idle(30);
    chk(!valid && count == 6, "R8 no rearm", count, 6);
    ref_clk = 0; fb_clk = 0; idle(4);

    measure(1, 3, 3, 0, 0, "R3 after rearm check");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule